// File: doc/BRIEF.md
# Rotation Phase Discriminator

This block turns the raw signals of a rotation sensor into motion steps and a direction. It works with two quadrature signals or with three commutation-style signals. A mode input picks one of the two. The sensor lines are synchronized into the module clock domain. A small state machine then follows the sequence of sensor codes. Each legal move to a neighbouring code gives a one-cycle step pulse and updates the direction bit. An up/down step counter follows the pulses.

A jump that skips a code, or a move onto a code the sequence never uses, sets a sticky error flag and gives no step. The block places no limit on how fast the inputs may toggle. The intended use keeps signal frequencies at or below one quarter of the module clock with two sensors, and one sixth with three.

Control states: `ST_FILL` waits while the synchronizer fills. `ST_LOAD` captures the current sensor code as the reference. `ST_TRACK` decodes. Named transitions:
- FILL_DONE (`ST_FILL` to `ST_LOAD`) fires after as many cycles as there are synchronizer stages.
- CAPTURE (`ST_LOAD` to `ST_TRACK`) always fires.
- In `ST_TRACK`, four self-transitions are chosen by comparing the current code with the reference: MODE_RESYNC, STEP, FAULT and IDLE.

Top module: `rot_phase_decoder`

## Requirements
- R1: In two-sensor mode (`mode_3s`=0) the code is {sens_in[1],sens_in[0]}. A move along 00→01→11→10→00 gives one step pulse with `dir_fwd`=1.
- R2: In two-sensor mode, a move along the reverse order (00→10→11→01→00) gives one step pulse with `dir_fwd`=0.
- R3: In three-sensor mode (`mode_3s`=1) the code is {sens_in[2],sens_in[1],sens_in[0]}. The forward order is 001→011→010→110→100→101→001; a move along it steps with `dir_fwd`=1. A move along the reverse order steps with `dir_fwd`=0.
- R4: Any one of the following moves sets `err_flag` and gives no step pulse: a move to a non-neighbouring code, a move from a legal code onto 000 or 111, or a move between two different illegal codes (000 and 111). A move from an illegal code onto a legal code is silent. The error flag stays set until reset.
- R5: With the default two synchronizer stages, a step pulse is high for exactly the one cycle after the third rising edge that follows the input change. `dir_fwd`, `err_flag` and `step_count` change on that same edge.
- R6: While reset is asserted, and just after it is released, `step_pulse`=0, `dir_fwd`=1, `err_flag`=0 and `step_count`=0. The sensor code present after release becomes the reference, and no step is given.
- R7: `step_count` rises by one on each forward step and falls by one on each backward step, modulo 2^STEP_W.
- R8: In two-sensor mode, `sens_in[2]` has no effect on any output.
- R9: A change of `mode_3s` makes the current code under the new mode the reference. It gives no step and does not change `err_flag`.
- R10: An input that stays the same gives no step. `dir_fwd` keeps its value between steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low reset |
| mode_3s | input | 1 | 0 = two-sensor quadrature, 1 = three-sensor |
| sens_in | input | 3 | Raw sensor lines (asynchronous) |
| step_pulse | output | 1 | One-cycle pulse per legal step |
| dir_fwd | output | 1 | Direction of the latest step, 1 = forward |
| err_flag | output | 1 | Sticky illegal-transition flag |
| step_count | output | STEP_W | Up/down step counter |

## Verification
The assertions check the following on every cycle:
- the error flag stays set once raised;
- the counter moves by exactly one in the direction of each pulse and holds otherwise;
- the direction bit holds between pulses;
- no step follows a classified fault or a mode resync, and none appears before tracking starts.

Only the bench scenarios can show the rest:
- that each sequence is decoded in the right direction, with the three-cycle latency;
- that the unused third line is ignored in two-sensor mode;
- that the counter wraps at both ends;
- that leaving an illegal three-sensor code is silent.

// File: rtl/rpd_pkg.sv
package rpd_pkg;

    localparam int SENS_W = 3;

    typedef enum logic [1:0] {
        ST_FILL  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_TRACK = 2'd2
    } rpd_state_e;

    typedef struct packed {
        logic       valid;
        logic [2:0] pos;
    } rpd_pos_t;

    // Map a sensor code to its position on the rotation sequence.
    function automatic rpd_pos_t code_to_pos(input logic [SENS_W-1:0] code,
                                             input logic three);
        rpd_pos_t r;
        r.valid = 1'b1;
        r.pos   = 3'd0;
        if (three) begin
            case (code)
                3'b001:  r.pos = 3'd0;
                3'b011:  r.pos = 3'd1;
                3'b010:  r.pos = 3'd2;
                3'b110:  r.pos = 3'd3;
                3'b100:  r.pos = 3'd4;
                3'b101:  r.pos = 3'd5;
                default: r.valid = 1'b0;
            endcase
        end else begin
            case (code[1:0])
                2'b00:   r.pos = 3'd0;
                2'b01:   r.pos = 3'd1;
                2'b11:   r.pos = 3'd2;
                default: r.pos = 3'd3;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/rpd_sync.sv
module rpd_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain[g] <= '0;
            end else begin
                chain[g] <= (g == 0) ? d : chain[(g == 0) ? 0 : g-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rpd_classify.sv
module rpd_classify
    import rpd_pkg::*;
(
    input  logic [SENS_W-1:0] prev_code,
    input  logic [SENS_W-1:0] cur_code,
    input  logic              three,
    output logic              fwd,
    output logic              bwd,
    output logic              bad
);
    rpd_pos_t   p, c;
    logic [2:0] last, nxt, prv;
    logic       moved;

    always_comb begin
        p     = code_to_pos(prev_code, three);
        c     = code_to_pos(cur_code, three);
        last  = three ? 3'd5 : 3'd3;
        nxt   = (p.pos == last) ? 3'd0 : p.pos + 3'd1;
        prv   = (p.pos == 3'd0) ? last : p.pos - 3'd1;
        moved = (cur_code != prev_code);
        fwd   = moved && p.valid && c.valid && (c.pos == nxt);
        bwd   = moved && p.valid && c.valid && (c.pos == prv);
        bad   = moved && !fwd && !bwd && (p.valid || !c.valid);
    end
endmodule

// File: rtl/rpd_step_counter.sv
module rpd_step_counter #(
    parameter int STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up,
    input  logic              down,
    output logic [STEP_W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (up) begin
            count <= count + 1'b1;
        end else if (down) begin
            count <= count - 1'b1;
        end
    end

    assert_up_down_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(up && down));
    assert_cnt_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
        up |=> count == $past(count) + 1'b1);
    assert_cnt_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
        down |=> count == $past(count) - 1'b1);
    assert_cnt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !up && !down |=> $stable(count));
endmodule

// File: rtl/rot_phase_decoder.sv
module rot_phase_decoder
    import rpd_pkg::*;
#(
    parameter int STEP_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_3s,
    input  logic [2:0]        sens_in,
    output logic              step_pulse,
    output logic              dir_fwd,
    output logic              err_flag,
    output logic [STEP_W-1:0] step_count
);
    localparam int FILL_W = $clog2(SYNC_STAGES + 1);

    rpd_state_e        state, state_nx;
    logic [FILL_W-1:0] fill_cnt;
    logic [SENS_W-1:0] sens_sync, cur_code, prev_code;
    logic              mode_q, mode_chg, cls_fwd, cls_bwd, cls_bad;
    logic              do_up, do_down;

    rpd_sync #(.WIDTH(SENS_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(sens_in), .q(sens_sync)
    );

    assign cur_code = mode_3s ? sens_sync : {1'b0, sens_sync[1:0]};
    assign mode_chg = (mode_3s != mode_q);

    rpd_classify u_cls (
        .prev_code(prev_code), .cur_code(cur_code), .three(mode_q),
        .fwd(cls_fwd), .bwd(cls_bwd), .bad(cls_bad)
    );

    assign do_up   = (state == ST_TRACK) && !mode_chg && cls_fwd;
    assign do_down = (state == ST_TRACK) && !mode_chg && cls_bwd;

    rpd_step_counter #(.STEP_W(STEP_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .up(do_up), .down(do_down), .count(step_count)
    );

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FILL:  if (fill_cnt == FILL_W'(SYNC_STAGES - 1)) state_nx = ST_LOAD;
            ST_LOAD:  state_nx = ST_TRACK;
            ST_TRACK: state_nx = ST_TRACK;
            default:  state_nx = ST_FILL;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_FILL;
            fill_cnt <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_FILL) fill_cnt <= fill_cnt + 1'b1;
        end
    end

    // Outputs and reference code
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_code  <= '0;
            mode_q     <= 1'b0;
            step_pulse <= 1'b0;
            dir_fwd    <= 1'b1;
            err_flag   <= 1'b0;
        end else begin
            step_pulse <= 1'b0;
            unique case (state)
                ST_FILL: ;
                ST_LOAD: begin
                    prev_code <= cur_code;
                    mode_q    <= mode_3s;
                end
                ST_TRACK: begin
                    if (mode_chg) begin
                        prev_code <= cur_code;
                        mode_q    <= mode_3s;
                    end else if (cur_code != prev_code) begin
                        prev_code <= cur_code;
                        if (cls_fwd) begin
                            step_pulse <= 1'b1;
                            dir_fwd    <= 1'b1;
                        end else if (cls_bwd) begin
                            step_pulse <= 1'b1;
                            dir_fwd    <= 1'b0;
                        end else if (cls_bad) begin
                            err_flag   <= 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assert_class_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cls_fwd, cls_bwd, cls_bad}));
    assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);
    assert_no_step_on_bad_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRACK && !mode_chg && cls_bad) |=> !step_pulse);
    assert_step_needs_move_R10: assert property (@(posedge clk) disable iff (!rst_n)
        step_pulse |-> $past(cur_code != prev_code));
    assert_dir_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !step_pulse |-> $stable(dir_fwd));
    assert_quiet_until_track_R6: assert property (@(posedge clk) disable iff (!rst_n)
        state != ST_TRACK |-> !step_pulse && !err_flag && step_count == '0);
    assert_resync_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRACK && mode_chg) |=> !step_pulse && $stable(err_flag));
endmodule

// File: tb/tb_rot_phase_decoder.sv
`timescale 1ns/1ps
module tb_rot_phase_decoder;
    localparam int STEP_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mode_3s = 1'b0;
    logic [2:0]        sens_in = 3'b000;
    logic              step_pulse, dir_fwd, err_flag;
    logic [STEP_W-1:0] step_count;

    int n_vec = 0;
    int n_bad = 0;

    logic [2:0]        m_prev;
    logic              m_three, m_dir, m_err;
    logic [STEP_W-1:0] m_cnt;

    always #4 clk = ~clk;

    rot_phase_decoder #(.STEP_W(STEP_W)) dut (
        .clk(clk), .rst_n(rst_n), .mode_3s(mode_3s), .sens_in(sens_in),
        .step_pulse(step_pulse), .dir_fwd(dir_fwd), .err_flag(err_flag),
        .step_count(step_count)
    );

    function automatic int ref_pos(input logic [2:0] code, input logic three);
        if (three) begin
            case (code)
                3'b001: return 0;
                3'b011: return 1;
                3'b010: return 2;
                3'b110: return 3;
                3'b100: return 4;
                3'b101: return 5;
                default: return -1;
            endcase
        end
        case (code[1:0])
            2'b00: return 0;
            2'b01: return 1;
            2'b11: return 2;
            default: return 3;
        endcase
    endfunction

    function automatic logic [2:0] ref_code(input int pos, input logic three);
        logic [2:0] seq3 [6] = '{3'b001, 3'b011, 3'b010, 3'b110, 3'b100, 3'b101};
        logic [2:0] seq2 [4] = '{3'b000, 3'b001, 3'b011, 3'b010};
        return three ? seq3[pos % 6] : seq2[pos % 4];
    endfunction

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic chk_all(input string req, input logic e_step);
        chk(req, "step_pulse", int'(step_pulse), int'(e_step));
        chk(req, "dir_fwd", int'(dir_fwd), int'(m_dir));
        chk(req, "err_flag", int'(err_flag), int'(m_err));
        chk(req, "step_count", int'(step_count), int'(m_cnt));
    endtask

    task automatic do_reset(input logic [2:0] raw, input logic three);
        @(negedge clk);
        rst_n   = 1'b0;
        sens_in = raw;
        mode_3s = three;
        repeat (3) @(negedge clk);
        chk("R6", "pulse in reset", int'(step_pulse), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        m_three = three;
        m_prev  = three ? raw : {1'b0, raw[1:0]};
        m_dir   = 1'b1;
        m_err   = 1'b0;
        m_cnt   = '0;
        chk_all("R6", 1'b0);
    endtask

    task automatic apply(input logic [2:0] raw, input string req);
        logic [2:0] eff;
        int         pp, pc, n, d;
        logic       e_step;
        @(negedge clk);
        sens_in = raw;
        eff     = m_three ? raw : {1'b0, raw[1:0]};
        n       = m_three ? 6 : 4;
        pp      = ref_pos(m_prev, m_three);
        pc      = ref_pos(eff, m_three);
        e_step  = 1'b0;
        if (eff != m_prev) begin
            if (pp >= 0 && pc >= 0) begin
                d = (pc - pp + n) % n;
                if (d == 1) begin
                    e_step = 1'b1; m_dir = 1'b1; m_cnt = m_cnt + 1'b1;
                end else if (d == n - 1) begin
                    e_step = 1'b1; m_dir = 1'b0; m_cnt = m_cnt - 1'b1;
                end else begin
                    m_err = 1'b1;
                end
            end else if (pc < 0) begin
                m_err = 1'b1;
            end
        end
        m_prev = eff;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_all(req, e_step);
        @(negedge clk);
        chk({req, "/R5"}, "pulse width", int'(step_pulse), 0);
    endtask

    task automatic set_mode(input logic three);
        @(negedge clk);
        mode_3s = three;
        m_three = three;
        m_prev  = three ? sens_in : {1'b0, sens_in[1:0]};
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk_all("R9", 1'b0);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        int unsigned seed;
        int          r, pos;
        logic [2:0]  nxt;
        seed = $urandom(32'd4711);

        // R6 reset and capture
        do_reset(3'b000, 1'b0);
        // R1 forward two-sensor sweep
        apply(3'b001, "R1"); apply(3'b011, "R1"); apply(3'b010, "R1"); apply(3'b000, "R1");
        // R2 reverse sweep
        apply(3'b010, "R2"); apply(3'b011, "R2"); apply(3'b001, "R2"); apply(3'b000, "R2");
        // R10 hold
        apply(3'b000, "R10");
        // R8 third line ignored in two-sensor mode
        apply(3'b100, "R8"); apply(3'b101, "R8"); apply(3'b001, "R8");
        // R4 skipped code, then sticky
        apply(3'b010, "R4"); apply(3'b000, "R4");
        // R3 three-sensor sequence
        do_reset(3'b001, 1'b1);
        apply(3'b011, "R3"); apply(3'b010, "R3"); apply(3'b110, "R3");
        apply(3'b100, "R3"); apply(3'b101, "R3"); apply(3'b001, "R3");
        apply(3'b101, "R3"); apply(3'b100, "R3");
        // R4 illegal code, silent leave, illegal-to-illegal
        apply(3'b111, "R4"); apply(3'b110, "R4");
        do_reset(3'b000, 1'b1);
        apply(3'b011, "R4");
        do_reset(3'b000, 1'b1);
        apply(3'b111, "R4");
        // R9 mode change
        do_reset(3'b011, 1'b0);
        set_mode(1'b1);
        apply(3'b010, "R9");
        set_mode(1'b0);
        apply(3'b011, "R9");
        // R7 wrap both ways
        do_reset(3'b000, 1'b0);
        apply(3'b010, "R7"); apply(3'b000, "R7");

        // Constrained random
        for (int v = 0; v < 400; v++) begin
            if (v % 100 == 50) do_reset(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)));
            if (v % 100 == 0) set_mode(~m_three);
            r   = $urandom_range(0, 99);
            pos = ref_pos(m_prev, m_three);
            if (pos < 0) pos = $urandom_range(0, 5);
            if (r < 45)       nxt = ref_code(pos + 1, m_three);
            else if (r < 85)  nxt = ref_code(pos + (m_three ? 5 : 3), m_three);
            else if (r < 93)  nxt = m_prev;
            else              nxt = 3'($urandom_range(0, 7));
            if (!m_three && r < 93) nxt[2] = 1'($urandom_range(0, 1));
            apply(nxt, m_three ? "R3/R4/R7" : "R1/R2/R8");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule